// File: doc/BRIEF.md
# Debug Abstract Register Access Unit

This block carries out abstract register-access commands for a hart debug module. A debugger talks to it over a small debug bus, with a 7-bit address, 32-bit write and read data and a two-bit operation code. It stages transfer data in four 32-bit message words. It accepts a command word that names a hart register, an access width and a direction. It reports progress and failure through a control/status word that holds a busy flag and a three-bit error code.

An accepted command is checked against the configured register width and the implemented register set. A legal command is then carried out over a request/acknowledge port into the hart register file. Read results are trimmed to the true width of narrow trace values before they land in the message words. Once an error code is set it freezes further command execution until the debugger clears it by writing ones to the code bits. The unit handles register x0 itself, without touching the hart.

Top module: `dbg_abs_unit`

## Requirements
- R1: After reset the busy flag and error code read as zero, all four message words read as zero and no hart request is raised.
- R2: Bus operation code 2 writes and code 1 reads, and read data appears on `bus_rdata_o` one cycle after the read operation. Message words sit at addresses 0x04 to 0x07 and carry value bits 31:0, 63:32, 95:64 and 127:96. Address 0x16 returns busy in bit 12 and the error code in bits 10:8. The command address 0x17 and all unmapped addresses read as zero.
- R3: A write of the command word to 0x17 starts an access when bit 17 is set. Bit 16 set means a write to the hart. Bits 22:20 are the size code (2 for 32, 3 for 64, 4 for 128 bits) and bits 15:0 are the register number. A hart write presents the concatenated message words, the register number, the size code and write enable, and holds the request until acknowledged.
- R4: Busy reads as 1 from the cycle after an accepted command until the acknowledge edge. A read result is latched into the message words covered by the size code (one, two or four words) at that same edge, and busy then reads 0.
- R5: A command write or a message-word write while busy sets error code 1 and leaves the message words unchanged. The running command still completes.
- R6: While the error code is nonzero, a command write is ignored: no hart request and no message-word change.
- R7: Writing the control/status word clears each error-code bit for which bit 10:8 of the written data is 1. Other error bits are kept.
- R8: A size code outside 2..4, or one wider than the configured register width, sets error code 2 without a hart request.
- R9: Register numbers 0xC000 to 0xC007 are read-only trace values. A write to them sets code 2. On a read, 0xC000 and 0xC004 return 1 bit, 0xC003 returns 2 bits and 0xC002 returns 32 bits, zero-extended. The others return full width.
- R10: Register numbers 0x1000+n (integer, n below the configured count), 0x1020..0x103F (floating point, when present) and 0x0301 are accepted. Any other number sets code 3 without a hart request. An acknowledge with the hart error flag sets code 3 and leaves the message words unchanged.
- R11: Register 0x1000 (x0) is served internally: a read loads zeros into the message words, a write is dropped, no hart request is raised and no error is set.
- R12: A command write with bit 17 clear does nothing: no busy, no error, no request.
- R13: The error code is only loaded while it is zero, so the first error of a sequence is the one reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_op_i | input | 2 | Debug bus operation: 0 idle, 1 read, 2 write |
| bus_addr_i | input | 7 | Debug bus word address |
| bus_wdata_i | input | 32 | Debug bus write data |
| bus_rdata_o | output | 32 | Debug bus read data, registered |
| hart_req_o | output | 1 | Register access request to the hart |
| hart_we_o | output | 1 | Access direction, 1 writes the hart register |
| hart_regno_o | output | 16 | Target register number |
| hart_size_o | output | 3 | Access size code |
| hart_wdata_o | output | XLEN | Data for hart register writes |
| hart_ack_i | input | 1 | Hart completes the request |
| hart_err_i | input | 1 | Hart reports a failed access, valid with acknowledge |
| hart_rdata_i | input | XLEN | Hart register read data, valid with acknowledge |

## Verification
The hardest situations to reach are those where a second event lands while a command is still in flight. These are a command or message write during busy, and a hart error arriving after a busy error has already been recorded. Both exist only inside the window between acceptance and acknowledge. The bench's hart model takes a programmable acknowledge latency and an error flag. The stimulus stretches the window to several cycles and issues the intruding bus write inside it, so that error priority and message-word protection can be observed afterwards through ordinary bus reads.

// File: rtl/dbg_abs_pkg.sv
package dbg_abs_pkg;
  localparam int unsigned NUM_MSG  = 4;
  localparam int unsigned MSG_W    = 32;
  localparam int unsigned WIDE_W   = NUM_MSG * MSG_W;

  localparam logic [6:0] ADDR_ACS = 7'h16;
  localparam logic [6:0] ADDR_CMD = 7'h17;
  localparam logic [4:0] ADDR_MSG_HI = 5'b00001;  // 0x04..0x07

  localparam int unsigned CMD_XFER_BIT = 17;
  localparam int unsigned CMD_WR_BIT   = 16;
  localparam int unsigned CMD_SIZE_LSB = 20;
  localparam int unsigned ACS_BUSY_BIT = 12;
  localparam int unsigned ACS_ERR_LSB  = 8;

  typedef enum logic [1:0] {BUS_NOP = 2'd0, BUS_RD = 2'd1, BUS_WR = 2'd2} bus_op_e;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_BUSY  = 3'd1,
    ERR_UNSUP = 3'd2,
    ERR_EXC   = 3'd3,
    ERR_HALT  = 3'd4,
    ERR_BUS   = 3'd5,
    ERR_OTHER = 3'd7
  } cmd_err_e;

  typedef enum logic [1:0] {ACT_HART = 2'd0, ACT_ZERO = 2'd1, ACT_FAIL = 2'd2} act_e;

  typedef struct packed {
    logic        write;
    logic [2:0]  size;
    logic [15:0] regno;
  } acc_cmd_t;
endpackage

// File: rtl/dbg_abs_decode.sv
module dbg_abs_decode import dbg_abs_pkg::*; #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NUM_GPR = 32,
  parameter bit          HAS_FPU = 1'b1
) (
  input  acc_cmd_t         cmd_i,
  output act_e             act_o,
  output cmd_err_e         err_o,
  output logic [XLEN-1:0]  mask_o
);
  localparam logic [2:0] MAX_SIZE = 3'($clog2(XLEN / 8));

  function automatic logic [XLEN-1:0] low_ones(int n);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = (i < n);
    return r;
  endfunction

  logic is_gpr, is_fpr, is_isa, is_trace, size_ok, gpr_missing;

  always_comb begin
    is_gpr      = (cmd_i.regno[15:5] == 11'h080);
    is_fpr      = (cmd_i.regno[15:5] == 11'h081);
    is_isa      = (cmd_i.regno == 16'h0301);
    is_trace    = (cmd_i.regno[15:3] == 13'h1800);
    size_ok     = (cmd_i.size >= 3'd2) && (cmd_i.size <= MAX_SIZE);
    gpr_missing = ({27'd0, cmd_i.regno[4:0]} >= 32'(NUM_GPR));

    act_o  = ACT_HART;
    err_o  = ERR_NONE;
    mask_o = '1;
    if (!size_ok) begin
      act_o = ACT_FAIL;
      err_o = ERR_UNSUP;
    end else if (is_gpr) begin
      if (gpr_missing) begin
        act_o = ACT_FAIL;
        err_o = ERR_EXC;
      end else if (cmd_i.regno[4:0] == 5'd0) begin
        act_o = ACT_ZERO;
      end
    end else if (is_fpr) begin
      if (!HAS_FPU) begin
        act_o = ACT_FAIL;
        err_o = ERR_EXC;
      end
    end else if (is_trace) begin
      if (cmd_i.write) begin
        act_o = ACT_FAIL;
        err_o = ERR_UNSUP;
      end else begin
        unique case (cmd_i.regno[2:0])
          3'd0, 3'd4: mask_o = low_ones(1);
          3'd3:       mask_o = low_ones(2);
          3'd2:       mask_o = low_ones(32);
          default:    mask_o = '1;
        endcase
      end
    end else if (!is_isa) begin
      act_o = ACT_FAIL;
      err_o = ERR_EXC;
    end
  end
endmodule

// File: rtl/dbg_abs_msg.sv
module dbg_abs_msg import dbg_abs_pkg::*; #(
  parameter int unsigned XLEN = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [1:0]          bus_idx_i,
  input  logic [MSG_W-1:0]    bus_wdata_i,
  input  logic                ld_en_i,
  input  logic [2:0]          ld_size_i,
  input  logic [XLEN-1:0]     ld_data_i,
  output logic [WIDE_W-1:0]   msg_o
);
  logic [WIDE_W-1:0] ld_wide;
  assign ld_wide = WIDE_W'(ld_data_i);

  for (genvar w = 0; w < NUM_MSG; w++) begin : g_word
    localparam int unsigned MIN_SIZE = (w == 0) ? 2 : (w == 1) ? 3 : 4;
    logic [MSG_W-1:0] word_q;
    logic             covered;

    assign covered = (ld_size_i >= 3'(MIN_SIZE));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              word_q <= '0;
      else if (ld_en_i && covered)              word_q <= ld_wide[w*MSG_W +: MSG_W];
      else if (bus_we_i && bus_idx_i == 2'(w))  word_q <= bus_wdata_i;
    end

    assign msg_o[w*MSG_W +: MSG_W] = word_q;
  end
endmodule

// File: rtl/dbg_abs_ctrl.sv
module dbg_abs_ctrl import dbg_abs_pkg::*; (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cmd_wr_i,
  input  acc_cmd_t  cmd_i,
  input  logic      xfer_i,
  input  logic      msg_wr_i,
  input  logic      acs_wr_i,
  input  logic [2:0] acs_clr_i,
  input  act_e      act_i,
  input  cmd_err_e  dec_err_i,
  input  logic      hart_ack_i,
  input  logic      hart_err_i,
  output logic      busy_o,
  output logic [2:0] err_o,
  output logic      hart_req_o,
  output acc_cmd_t  cmd_q_o,
  output logic      zero_o,
  output logic      ld_o
);
  logic     busy_q, zero_q;
  logic [2:0] err_q, err_base, err_set, err_d;
  acc_cmd_t cmd_q;
  logic     accept, start, fail, finish;

  always_comb begin
    accept = cmd_wr_i && !busy_q && (err_q == 3'd0) && xfer_i;
    start  = accept && (act_i != ACT_FAIL);
    fail   = accept && (act_i == ACT_FAIL);
    finish = busy_q && (zero_q || hart_ack_i);
    ld_o   = finish && !cmd_q.write && (zero_q || !hart_err_i);

    if (busy_q && (cmd_wr_i || msg_wr_i))                  err_set = ERR_BUSY;
    else if (fail)                                         err_set = dec_err_i;
    else if (busy_q && !zero_q && hart_ack_i && hart_err_i) err_set = ERR_EXC;
    else                                                   err_set = ERR_NONE;

    err_base = err_q & ~(acs_wr_i ? acs_clr_i : 3'b000);
    err_d    = (err_base == 3'd0) ? err_set : err_base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      zero_q <= 1'b0;
      err_q  <= 3'd0;
      cmd_q  <= '0;
    end else begin
      err_q <= err_d;
      if (start) begin
        busy_q <= 1'b1;
        zero_q <= (act_i == ACT_ZERO);
        cmd_q  <= cmd_i;
      end else if (finish) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o     = busy_q;
  assign err_o      = err_q;
  assign hart_req_o = busy_q && !zero_q;
  assign cmd_q_o    = cmd_q;
  assign zero_o     = zero_q;
endmodule

// File: rtl/dbg_abs_unit.sv
module dbg_abs_unit import dbg_abs_pkg::*; #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NUM_GPR = 32,
  parameter bit          HAS_FPU = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      bus_op_i,
  input  logic [6:0]      bus_addr_i,
  input  logic [31:0]     bus_wdata_i,
  output logic [31:0]     bus_rdata_o,
  output logic            hart_req_o,
  output logic            hart_we_o,
  output logic [15:0]     hart_regno_o,
  output logic [2:0]      hart_size_o,
  output logic [XLEN-1:0] hart_wdata_o,
  input  logic            hart_ack_i,
  input  logic            hart_err_i,
  input  logic [XLEN-1:0] hart_rdata_i
);
  logic        wr, msg_hit, cmd_wr, acs_wr, msg_wr;
  logic        busy, zero, ld;
  logic [2:0]  err;
  acc_cmd_t    new_cmd, cmd_q, dec_cmd;
  act_e        act;
  cmd_err_e    dec_err;
  logic [XLEN-1:0]   mask, ld_data;
  logic [WIDE_W-1:0] msg;
  logic [31:0] rd_mux, rdata_q;
  logic        unused_wdata;

  assign wr      = (bus_op_i == BUS_WR);
  assign msg_hit = (bus_addr_i[6:2] == ADDR_MSG_HI);
  assign msg_wr  = wr && msg_hit;
  assign cmd_wr  = wr && (bus_addr_i == ADDR_CMD);
  assign acs_wr  = wr && (bus_addr_i == ADDR_ACS);

  assign new_cmd.write = bus_wdata_i[CMD_WR_BIT];
  assign new_cmd.size  = bus_wdata_i[CMD_SIZE_LSB +: 3];
  assign new_cmd.regno = bus_wdata_i[15:0];
  assign unused_wdata  = ^{bus_wdata_i[31:23], bus_wdata_i[19:18]};

  // one decoder: incoming command when idle, held command (for read mask) when busy
  assign dec_cmd = busy ? cmd_q : new_cmd;

  dbg_abs_decode #(.XLEN(XLEN), .NUM_GPR(NUM_GPR), .HAS_FPU(HAS_FPU)) u_dec (
    .cmd_i  (dec_cmd),
    .act_o  (act),
    .err_o  (dec_err),
    .mask_o (mask)
  );

  dbg_abs_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_wr_i   (cmd_wr),
    .cmd_i      (new_cmd),
    .xfer_i     (bus_wdata_i[CMD_XFER_BIT]),
    .msg_wr_i   (msg_wr),
    .acs_wr_i   (acs_wr),
    .acs_clr_i  (bus_wdata_i[ACS_ERR_LSB +: 3]),
    .act_i      (act),
    .dec_err_i  (dec_err),
    .hart_ack_i (hart_ack_i),
    .hart_err_i (hart_err_i),
    .busy_o     (busy),
    .err_o      (err),
    .hart_req_o (hart_req_o),
    .cmd_q_o    (cmd_q),
    .zero_o     (zero),
    .ld_o       (ld)
  );

  assign ld_data = zero ? '0 : (hart_rdata_i & mask);

  dbg_abs_msg #(.XLEN(XLEN)) u_msg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (msg_wr && !busy),
    .bus_idx_i   (bus_addr_i[1:0]),
    .bus_wdata_i (bus_wdata_i),
    .ld_en_i     (ld),
    .ld_size_i   (cmd_q.size),
    .ld_data_i   (ld_data),
    .msg_o       (msg)
  );

  always_comb begin
    rd_mux = '0;
    if (msg_hit) begin
      rd_mux = msg[bus_addr_i[1:0]*MSG_W +: MSG_W];
    end else if (bus_addr_i == ADDR_ACS) begin
      rd_mux[ACS_BUSY_BIT]       = busy;
      rd_mux[ACS_ERR_LSB +: 3]   = err;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rdata_q <= '0;
    else if (bus_op_i == BUS_RD)    rdata_q <= rd_mux;
  end

  assign bus_rdata_o  = rdata_q;
  assign hart_we_o    = cmd_q.write;
  assign hart_regno_o = cmd_q.regno;
  assign hart_size_o  = cmd_q.size;
  assign hart_wdata_o = msg[XLEN-1:0];
endmodule

// File: rtl/dbg_abs_unit_chk.sv
module dbg_abs_unit_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_i,
  input logic [2:0]  err_i,
  input logic        hart_req_i,
  input logic        hart_ack_i,
  input logic        hart_we_i,
  input logic [15:0] hart_regno_i,
  input logic [2:0]  hart_size_i,
  input logic        cmd_wr_i,
  input logic        acs_wr_i
);
  localparam logic [2:0] MAX_SIZE = 3'($clog2(XLEN / 8));

  a_r4_req_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hart_req_i |-> busy_i);

  a_r3_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hart_req_i && !hart_ack_i) |=> (hart_req_i && $stable(hart_regno_i) && $stable(hart_we_i)));

  a_r5_busy_write_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cmd_wr_i) |=> (err_i != 3'd0));

  a_r6_err_blocks_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i != 3'd0 && !busy_i) |=> !busy_i);

  a_r8_size_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hart_req_i |-> (hart_size_i >= 3'd2 && hart_size_i <= MAX_SIZE));

  a_r9_no_trace_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hart_req_i && hart_we_i) |-> (hart_regno_i[15:3] != 13'h1800));

  a_r13_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i != 3'd0 && !acs_wr_i) |=> (err_i == $past(err_i)));
endmodule

bind dbg_abs_unit dbg_abs_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_i       (busy),
  .err_i        (err),
  .hart_req_i   (hart_req_o),
  .hart_ack_i   (hart_ack_i),
  .hart_we_i    (hart_we_o),
  .hart_regno_i (hart_regno_o),
  .hart_size_i  (hart_size_o),
  .cmd_wr_i     (cmd_wr),
  .acs_wr_i     (acs_wr)
);

// File: tb/dbg_abs_unit_tb.sv
module dbg_abs_unit_tb;
  localparam int unsigned XLEN = 64;
  localparam logic [6:0] A_ACS = 7'h16;
  localparam logic [6:0] A_CMD = 7'h17;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      op = 2'd0;
  logic [6:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            hreq, hwe, hack, herr;
  logic [15:0]     hregno;
  logic [2:0]      hsize;
  logic [XLEN-1:0] hwdata, hrdata;

  int tests = 0;
  int fails = 0;
  int hart_lat = 0;
  bit force_err = 1'b0;
  int lat_cnt = 0;
  logic [63:0] hreg [0:79];

  always #10 clk = ~clk;

  dbg_abs_unit #(.XLEN(XLEN), .NUM_GPR(16), .HAS_FPU(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_op_i(op), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .hart_req_o(hreq), .hart_we_o(hwe), .hart_regno_o(hregno), .hart_size_o(hsize),
    .hart_wdata_o(hwdata), .hart_ack_i(hack), .hart_err_i(herr), .hart_rdata_i(hrdata)
  );

  function automatic int hidx(logic [15:0] r);
    if (r[15:12] == 4'hC) return 72 + int'(r[2:0]);
    if (r == 16'h0301)    return 64;
    return int'(r[5:0]);
  endfunction

  // hart register file model with programmable latency
  initial begin
    hack = 1'b0; herr = 1'b0; hrdata = '0;
    for (int i = 0; i < 80; i++) hreg[i] = '0;
    for (int i = 72; i < 80; i++) hreg[i] = '1;
    hreg[73] = 64'h8000_0000_0000_1234;
    forever begin
      @(negedge clk);
      if (hreq && !hack) begin
        if (lat_cnt >= hart_lat) begin
          hack = 1'b1;
          herr = force_err;
          hrdata = hreg[hidx(hregno)];
          if (hwe && !force_err) hreg[hidx(hregno)] = (hsize == 3'd2) ? {32'd0, hwdata[31:0]} : hwdata;
          lat_cnt = 0;
        end else lat_cnt++;
      end else begin
        hack = 1'b0;
        herr = 1'b0;
      end
    end
  end

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); op = 2'd2; addr = a; wdata = d;
    @(negedge clk); op = 2'd0;
  endtask

  task automatic bus_rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); op = 2'd1; addr = a;
    @(negedge clk); op = 2'd0; d = rdata;
  endtask

  function automatic logic [31:0] cmd(bit w, logic [2:0] sz, logic [15:0] r, bit xfer = 1'b1);
    return {9'd0, sz, 2'd0, xfer, w, r};
  endfunction

  task automatic wait_idle(output logic [31:0] acs);
    for (int i = 0; i < 60; i++) begin
      bus_rd(A_ACS, acs);
      if (!acs[12]) break;
    end
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [31:0] lo, hi;
    bus_rd(7'h04, lo);
    bus_rd(7'h05, hi);
    v = {hi, lo};
  endtask

  typedef struct packed {
    logic [15:0] regno;
    logic [2:0]  size;
    logic [63:0] data;
    logic [2:0]  werr;
    logic [2:0]  rerr;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{16'h1005, 3'd3, 64'hA5A5_0000_1234_5678, 3'd0, 3'd0, 64'hA5A5_0000_1234_5678},
    '{16'h1000, 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 3'd0, 64'h0},
    '{16'h1023, 3'd3, 64'h0123_4567_89AB_CDEF, 3'd0, 3'd0, 64'h0123_4567_89AB_CDEF},
    '{16'h0301, 3'd3, 64'h8000_0000_0014_1101, 3'd0, 3'd0, 64'h8000_0000_0014_1101},
    '{16'h1010, 3'd3, 64'h1111_2222_3333_4444, 3'd3, 3'd3, 64'h1111_2222_3333_4444},
    '{16'h1007, 3'd2, 64'hDEAD_BEEF_CAFE_F00D, 3'd0, 3'd0, 64'hDEAD_BEEF_CAFE_F00D},
    '{16'h1009, 3'd4, 64'h5555_6666_7777_8888, 3'd2, 3'd2, 64'h5555_6666_7777_8888},
    '{16'hC002, 3'd3, 64'h0BAD_0BAD_0BAD_0BAD, 3'd2, 3'd0, 64'h0000_0000_FFFF_FFFF},
    '{16'hC003, 3'd3, 64'h0BAD_0BAD_0BAD_0BAD, 3'd2, 3'd0, 64'h3},
    '{16'hC001, 3'd3, 64'h0BAD_0BAD_0BAD_0BAD, 3'd2, 3'd0, 64'h8000_0000_0000_1234},
    '{16'hC004, 3'd3, 64'h0BAD_0BAD_0BAD_0BAD, 3'd2, 3'd0, 64'h1},
    '{16'h2000, 3'd3, 64'h9999_8888_7777_6666, 3'd3, 3'd3, 64'h9999_8888_7777_6666},
    '{16'h1003, 3'd1, 64'h4444_3333_2222_1111, 3'd2, 3'd2, 64'h4444_3333_2222_1111}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] v64;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 req after reset", 64'(hreq), 64'd0);
    bus_rd(A_ACS, v);  chk("R1 acs after reset", 64'(v), 64'd0);
    for (int a = 4; a < 8; a++) begin
      bus_rd(7'(a), v); chk("R1 msg word after reset", 64'(v), 64'd0);
    end

    // R2 bus map
    bus_wr(7'h06, 32'h1357_2468);
    bus_wr(7'h07, 32'h9ABC_DEF0);
    bus_rd(7'h06, v);  chk("R2 msg word 2", 64'(v), 64'h1357_2468);
    bus_rd(7'h07, v);  chk("R2 msg word 3", 64'(v), 64'h9ABC_DEF0);
    bus_rd(A_CMD, v);  chk("R2 command reads zero", 64'(v), 64'd0);
    bus_wr(7'h30, 32'hFFFF_FFFF);
    bus_rd(7'h30, v);  chk("R2 unmapped reads zero", 64'(v), 64'd0);

    // R12 transfer clear
    bus_wr(A_CMD, cmd(1'b0, 3'd3, 16'h1005, 1'b0));
    chk("R12 no request", 64'(hreq), 64'd0);
    bus_rd(A_ACS, v);  chk("R12 acs idle", 64'(v), 64'd0);

    // R3 / R4 hart write with latency
    hart_lat = 2;
    bus_wr(7'h04, 32'h5566_7788);
    bus_wr(7'h05, 32'h1122_3344);
    bus_wr(A_CMD, cmd(1'b1, 3'd3, 16'h1006));
    chk("R3 request raised", 64'(hreq), 64'd1);
    chk("R3 write enable", 64'(hwe), 64'd1);
    chk("R3 regno", 64'(hregno), 64'h1006);
    chk("R3 size", 64'(hsize), 64'd3);
    chk("R3 wdata", hwdata, 64'h1122_3344_5566_7788);
    bus_rd(A_ACS, v);  chk("R4 busy while pending", 64'(v[12]), 64'd1);
    wait_idle(v);      chk("R4 write done no error", 64'(v), 64'd0);
    chk("R3 hart register written", hreg[6], 64'h1122_3344_5566_7788);
    bus_wr(7'h04, 32'd0);
    bus_wr(7'h05, 32'd0);
    bus_wr(A_CMD, cmd(1'b0, 3'd3, 16'h1006));
    wait_idle(v);      chk("R4 read done no error", 64'(v), 64'd0);
    chk("R4 request dropped", 64'(hreq), 64'd0);
    rd64(v64);         chk("R4 read latched", v64, 64'h1122_3344_5566_7788);
    hart_lat = 0;

    // vector table: write, read back (R8 R9 R10 R11 among them)
    for (int i = 0; i < 13; i++) begin
      bus_wr(7'h04, VECS[i].data[31:0]);
      bus_wr(7'h05, VECS[i].data[63:32]);
      bus_wr(A_CMD, cmd(1'b1, VECS[i].size, VECS[i].regno));
      wait_idle(v);
      chk("R8/R9/R10/R11 write error code", 64'(v[10:8]), 64'(VECS[i].werr));
      bus_wr(A_ACS, 32'h700);
      bus_wr(A_CMD, cmd(1'b0, VECS[i].size, VECS[i].regno));
      wait_idle(v);
      chk("R8/R9/R10/R11 read error code", 64'(v[10:8]), 64'(VECS[i].rerr));
      bus_wr(A_ACS, 32'h700);
      rd64(v64);
      chk("R9/R11 read-back value", v64, VECS[i].exp);
    end

    // R11 x0 raises no hart request
    bus_wr(A_CMD, cmd(1'b0, 3'd3, 16'h1000));
    chk("R11 no request for x0", 64'(hreq), 64'd0);
    wait_idle(v);      chk("R11 x0 no error", 64'(v), 64'd0);

    // R5 message write while busy
    bus_wr(7'h05, 32'h1111_1111);
    hart_lat = 5;
    bus_wr(A_CMD, cmd(1'b0, 3'd2, 16'h1005));
    bus_wr(7'h05, 32'h2222_2222);
    wait_idle(v);      chk("R5 busy error code", 64'(v[10:8]), 64'd1);
    bus_rd(7'h05, v);  chk("R5 msg word protected", 64'(v), 64'h1111_1111);
    bus_rd(7'h04, v);  chk("R5 running command completed", 64'(v), 64'h1234_5678);
    bus_wr(A_ACS, 32'h700);

    // R13 first error wins over later hart error
    hart_lat = 4;
    force_err = 1'b1;
    bus_wr(A_CMD, cmd(1'b0, 3'd3, 16'h1005));
    bus_wr(A_CMD, cmd(1'b0, 3'd3, 16'h1006));
    wait_idle(v);      chk("R13 first error kept", 64'(v[10:8]), 64'd1);
    bus_wr(A_ACS, 32'h700);

    // R10 hart error
    hart_lat = 0;
    bus_wr(7'h04, 32'hAAAA_0000);
    bus_wr(A_CMD, cmd(1'b0, 3'd2, 16'h1005));
    wait_idle(v);      chk("R10 hart error code", 64'(v[10:8]), 64'd3);
    bus_rd(7'h04, v);  chk("R10 msg unchanged on hart error", 64'(v), 64'hAAAA_0000);
    force_err = 1'b0;

    // R6 error blocks new commands
    bus_wr(A_CMD, cmd(1'b0, 3'd2, 16'h1005));
    chk("R6 no request while error", 64'(hreq), 64'd0);
    bus_rd(A_ACS, v);  chk("R6 error kept", 64'(v), 64'h300);
    bus_rd(7'h04, v);  chk("R6 msg unchanged", 64'(v), 64'hAAAA_0000);

    // R7 write-one-to-clear per bit
    bus_wr(A_ACS, 32'h100);
    bus_rd(A_ACS, v);  chk("R7 clear bit 8", 64'(v[10:8]), 64'd2);
    bus_wr(A_ACS, 32'h400);
    bus_rd(A_ACS, v);  chk("R7 zero bits keep code", 64'(v[10:8]), 64'd2);
    bus_wr(A_ACS, 32'h200);
    bus_rd(A_ACS, v);  chk("R7 fully cleared", 64'(v), 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule